// File: doc/BRIEF.md
# Commit-Stage Interrupt Admission Gate

This block decides when an external interrupt may enter the commit stage of an out-of-order core, for thread 0 only. It samples a request code and, when the conditions allow, captures that code in a holding register. While a code is held, it drives a level to the front end so that fetch can stop. The block then waits until the reorder buffer has drained and no stores are left to write back.

When both of those hold, the block admits the interrupt in that same cycle. It pulses a clear to the interrupt source, passes the held code to the trap handler, and asks the squash controller for a trap squash. On the next edge it marks thread 0 as trap-pending and empties the holding register. Trap-pending stays set until the squash controller reports that the trap squash is done.

The handoff to the handler is a one-cycle valid pulse that carries the code. It has no ready input: the handler must take it in that cycle. The request input is a plain level and is not acknowledged.

Top module: `irq_admit_gate`

## Requirements
- R1: After reset, `irq_pend_o`, `trap_pend_o`, `irq_clr_o`, `hnd_vld_o` and `trap_req_o` are all 0.
- R2: A nonzero `irq_code_i` is captured at a clock edge when all of the following hold: `irq_en_i`=1, `trap_pend_o`=0, `trap_sq_pend_i`=0 and `ctx_sq_pend_i`=0. `irq_pend_o` is 1 from the next cycle on.
- R3: No code is captured while `irq_en_i`=0, `trap_sq_pend_i`=1 or `ctx_sq_pend_i`=1.
- R4: No code is captured while `trap_pend_o`=1.
- R5: Code value 0 means "no interrupt" and is never captured.
- R6: A held code stays held while `rob_empty_i`=0 or `st_pend_i`=1. A different nonzero request arriving meanwhile does not replace it.
- R7: If `irq_code_i` returns to 0 while a code is held, the held interrupt is still admitted later.
- R8: In any cycle where a code is held, `rob_empty_i`=1 and `st_pend_i`=0, the block admits it combinationally. `irq_clr_o`, `hnd_vld_o` and `trap_req_o` are 1 for that one cycle, and `hnd_code_o` equals the held code.
- R9: The cycle after an admission, `irq_pend_o`=0 and `trap_pend_o`=1.
- R10: `trap_pend_o` returns to 0 on the edge after `trap_done_i`=1.
- R11: No admission happens while `trap_pend_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_code_i | input | 4 | Requested interrupt code, 0 = none |
| irq_en_i | input | 1 | Interrupts enabled for thread 0 |
| trap_sq_pend_i | input | 1 | A trap squash is already pending |
| ctx_sq_pend_i | input | 1 | A thread-context squash is pending |
| rob_empty_i | input | 1 | Reorder buffer holds no thread-0 entries |
| st_pend_i | input | 1 | Stores still waiting to write back |
| trap_done_i | input | 1 | Squash controller finished the trap squash |
| irq_pend_o | output | 1 | Interrupt held, front end should stop fetch |
| irq_clr_o | output | 1 | One-cycle clear to the interrupt source |
| hnd_vld_o | output | 1 | One-cycle handoff to the trap handler |
| hnd_code_o | output | 4 | Code handed to the handler |
| trap_req_o | output | 1 | One-cycle trap squash request |
| trap_pend_o | output | 1 | Thread 0 is in trap-pending state |

## Verification
The assertions assume that `trap_done_i` is raised only while thread 0 is trap-pending, and never in the same cycle as an admission. They also assume that the handler takes every handoff pulse without back-pressure. The stimulus raises the done input only after it has seen `trap_pend_o` high. It drives all inputs on the falling edge, so the held code and the admission conditions never change in the middle of a cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned CODE_W = 4;
  typedef logic [CODE_W-1:0] irq_code_t;
  localparam irq_code_t NO_IRQ = '0;
endpackage

// File: rtl/irq_hold.sv
module irq_hold
  import irq_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_code_t req_code,
  input  logic      sample_ok,
  input  logic      admit,
  output irq_code_t held_code
);
  irq_code_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= NO_IRQ;
    end else if (held_q != NO_IRQ) begin
      if (admit) held_q <= NO_IRQ;
    end else if (sample_ok && req_code != NO_IRQ) begin
      held_q <= req_code;
    end
  end

  assign held_code = held_q;

  // R6: a held code is neither replaced nor lost until it is admitted
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q != NO_IRQ && !admit) |=> held_q == $past(held_q));
  // R5: the zero code never enters the holder from an empty state
  a_r5_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q == NO_IRQ && req_code == NO_IRQ) |=> held_q == NO_IRQ);
endmodule

// File: rtl/trap_state.sv
module trap_state (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_set,
  input  logic trap_done,
  output logic trap_pend
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (trap_set)  pend_q <= 1'b1;
    else if (trap_done) pend_q <= 1'b0;
  end

  assign trap_pend = pend_q;

  // R9: an admission leaves thread 0 trap-pending
  a_r9_set_after_admit: assert property (@(posedge clk) disable iff (!rst_n)
    trap_set |=> pend_q);
  // R10: done clears the state when no new admission competes
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_done && !trap_set) |=> !pend_q);
endmodule

// File: rtl/irq_admit_gate.sv
module irq_admit_gate
  import irq_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_code_i,
  input  logic       irq_en_i,
  input  logic       trap_sq_pend_i,
  input  logic       ctx_sq_pend_i,
  input  logic       rob_empty_i,
  input  logic       st_pend_i,
  input  logic       trap_done_i,
  output logic       irq_pend_o,
  output logic       irq_clr_o,
  output logic       hnd_vld_o,
  output logic [3:0] hnd_code_o,
  output logic       trap_req_o,
  output logic       trap_pend_o
);
  irq_code_t held;
  logic      trap_pend;
  logic      sample_ok;
  logic      quiesced;
  logic      admit;

  // Sampling is suppressed while any trap or squash is outstanding.
  assign sample_ok = irq_en_i && !trap_pend && !trap_sq_pend_i && !ctx_sq_pend_i;
  assign quiesced  = rob_empty_i && !st_pend_i;
  assign admit     = (held != NO_IRQ) && quiesced;

  irq_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_code  (irq_code_i),
    .sample_ok (sample_ok),
    .admit     (admit),
    .held_code (held)
  );

  trap_state u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_set  (admit),
    .trap_done (trap_done_i),
    .trap_pend (trap_pend)
  );

  assign irq_pend_o  = held != NO_IRQ;
  assign irq_clr_o   = admit;
  assign hnd_vld_o   = admit;
  assign hnd_code_o  = admit ? held : NO_IRQ;
  assign trap_req_o  = admit;
  assign trap_pend_o = trap_pend;

  // R11: the trap-pending state is never already set at an admission
  a_r11_no_double_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_vld_o |-> !trap_pend_o);
  // R4: no capture happens while trap-pending
  a_r4_no_sample_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend_o && !irq_pend_o) |=> !irq_pend_o);
  // R3: a rising pending level needs all sampling conditions in the prior cycle
  a_r3_gated_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend_o) |-> $past(irq_en_i && !trap_sq_pend_i && !ctx_sq_pend_i));
  // R9: the holder is empty after an admission
  a_r9_held_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_vld_o |=> !irq_pend_o);
  // R8: an admission only happens on a quiet machine
  a_r8_quiet_only: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> (rob_empty_i && !st_pend_i && irq_pend_o));
endmodule

// File: tb/irq_admit_gate_bench.sv
module irq_admit_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] irq_code_i;
  logic       irq_en_i, trap_sq_pend_i, ctx_sq_pend_i;
  logic       rob_empty_i, st_pend_i, trap_done_i;
  logic       irq_pend_o, irq_clr_o, hnd_vld_o, trap_req_o, trap_pend_o;
  logic [3:0] hnd_code_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_admit_gate u_irq_admit_gate (
    .clk(clk), .rst_n(rst_n), .irq_code_i(irq_code_i), .irq_en_i(irq_en_i),
    .trap_sq_pend_i(trap_sq_pend_i), .ctx_sq_pend_i(ctx_sq_pend_i),
    .rob_empty_i(rob_empty_i), .st_pend_i(st_pend_i), .trap_done_i(trap_done_i),
    .irq_pend_o(irq_pend_o), .irq_clr_o(irq_clr_o), .hnd_vld_o(hnd_vld_o),
    .hnd_code_o(hnd_code_o), .trap_req_o(trap_req_o), .trap_pend_o(trap_pend_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one edge; inputs change at negedge, sample 1 ns later.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    irq_code_i = 4'd0; irq_en_i = 1'b1; trap_sq_pend_i = 1'b0; ctx_sq_pend_i = 1'b0;
    rob_empty_i = 1'b0; st_pend_i = 1'b0; trap_done_i = 1'b0;
  endtask

  task automatic finish_trap();
    idle_inputs();
    trap_done_i = 1'b1;
    step();
    trap_done_i = 1'b0;
    chk("R10 trap_pend cleared", {7'd0, trap_pend_o}, 8'd0);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    step(); step();
    chk("R1 pend", {7'd0, irq_pend_o}, 8'd0);
    chk("R1 trap_pend", {7'd0, trap_pend_o}, 8'd0);
    chk("R1 pulses", {5'd0, irq_clr_o, hnd_vld_o, trap_req_o}, 8'd0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_basic();
    irq_code_i = 4'd5;
    step();
    chk("R2 captured", {7'd0, irq_pend_o}, 8'd1);
    chk("R6 waits rob", {7'd0, hnd_vld_o}, 8'd0);
    irq_code_i = 4'd0;
    rob_empty_i = 1'b1;
    #1;
    chk("R8 clr", {7'd0, irq_clr_o}, 8'd1);
    chk("R8 hnd", {7'd0, hnd_vld_o}, 8'd1);
    chk("R8 code", {4'd0, hnd_code_o}, 8'd5);
    chk("R8 trap_req", {7'd0, trap_req_o}, 8'd1);
    step();
    rob_empty_i = 1'b0;
    #1;
    chk("R9 pend cleared", {7'd0, irq_pend_o}, 8'd0);
    chk("R9 trap_pend", {7'd0, trap_pend_o}, 8'd1);
    chk("R8 single pulse", {7'd0, hnd_vld_o}, 8'd0);
    irq_code_i = 4'd3;
    step();
    chk("R4 blocked in trap", {7'd0, irq_pend_o}, 8'd0);
    finish_trap();
  endtask

  task automatic t_blockers();
    irq_code_i = 4'd7; irq_en_i = 1'b0;
    step();
    chk("R3 disabled", {7'd0, irq_pend_o}, 8'd0);
    irq_en_i = 1'b1; trap_sq_pend_i = 1'b1;
    step();
    chk("R3 trap squash", {7'd0, irq_pend_o}, 8'd0);
    trap_sq_pend_i = 1'b0; ctx_sq_pend_i = 1'b1;
    step();
    chk("R3 ctx squash", {7'd0, irq_pend_o}, 8'd0);
    ctx_sq_pend_i = 1'b0; irq_code_i = 4'd0;
    step();
    chk("R5 zero code", {7'd0, irq_pend_o}, 8'd0);
  endtask

  task automatic t_hold_and_drop();
    irq_code_i = 4'd9;
    step();
    chk("R2 captured 9", {7'd0, irq_pend_o}, 8'd1);
    irq_code_i = 4'd2; rob_empty_i = 1'b1; st_pend_i = 1'b1;
    step();
    chk("R6 stores block", {7'd0, hnd_vld_o}, 8'd0);
    irq_code_i = 4'd0;
    step();
    chk("R7 still pending after drop", {7'd0, irq_pend_o}, 8'd1);
    st_pend_i = 1'b0;
    #1;
    chk("R7 admitted after drop", {7'd0, hnd_vld_o}, 8'd1);
    chk("R6 not replaced", {4'd0, hnd_code_o}, 8'd9);
    step();
    rob_empty_i = 1'b0;
    chk("R9 trap_pend 2", {7'd0, trap_pend_o}, 8'd1);
    rob_empty_i = 1'b1; irq_code_i = 4'd4;
    step();
    chk("R11 no admission in trap", {7'd0, hnd_vld_o}, 8'd0);
    finish_trap();
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    t_reset();
    t_basic();
    t_blockers();
    t_hold_and_drop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule